// File: doc/BRIEF.md
# Double-buffered SPI master engine

This block is the transfer core of an SPI master. A host places characters into a one-entry holding register. The engine moves each character into a separate shift register as soon as the shifter is free. It then generates the serial clock from a programmable divider, drives MOSI and samples MISO. Because the holding register is separate from the shifter, the host can queue the next character while the current one is still on the wire. Successive characters then follow with a single system-clock gap between frames.

Three status flags report progress:
- holding register empty,
- shifter finished with nothing queued,
- received character waiting.

A sticky overflow flag records a received character that arrived before the previous one was read. Clock polarity, clock phase, bit order and character length (8 or 9 bits) are static configuration inputs, changed only while the engine is idle. Slave select is not part of the block; the surrounding logic drives it as an ordinary output.

Top module: `spi_master_engine`

## Requirements
- R1: After reset, flag_dre is 1, flag_txc, flag_rxc, flag_ovf and wr_reject are 0, rd_data is 0, and sck equals cfg_cpol.
- R2: A write (wr_valid high on a clock edge) while flag_dre is 0 is discarded. wr_reject is 1 for the single cycle that follows, and the discarded character never appears on MOSI.
- R3: A write while flag_dre is 1 is taken: flag_dre drops for the next cycle. The holding register moves into the shifter on the first edge at which the shifter is idle, and flag_dre returns to 1 on that edge.
- R4: While a character is shifted, sck toggles every cfg_baud+1 system clocks, giving 2·N toggles per N-bit character. Between characters sck rests at cfg_cpol.
- R5: The first toggle of each SCK period is the leading edge. With cfg_cpha=0 both sides sample on leading edges and change data on trailing edges. With cfg_cpha=1 they change data on leading edges and sample on trailing edges.
- R6: With cfg_lsb_first=1, bit 0 is sent and received first. With cfg_lsb_first=0, the most significant bit of the character is first.
- R7: With cfg_nine_bit=1 a character is wr_data[8:0]. With cfg_nine_bit=0 it is wr_data[7:0]: bit 8 is not sent and rd_data[8] reads 0.
- R8: flag_txc sets when a frame ends while the holding register is empty, and clears on an accepted write.
- R9: With cfg_rx_en=1, each received character is placed in rd_data at frame end and flag_rxc sets; a one-cycle rd_strobe clears flag_rxc. With cfg_rx_en=0, flag_rxc stays 0 and rd_data is unchanged.
- R10: A frame that ends with flag_rxc already 1 sets flag_ovf, and rd_data takes the newer character. A one-cycle ovf_clear pulse clears flag_ovf and leaves flag_rxc alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_nine_bit | input | 1 | 1: 9-bit characters, 0: 8-bit |
| cfg_rx_en | input | 1 | Receiver enable |
| cfg_baud | input | BAUD_W | SCK half period minus one, in system clocks |
| wr_valid | input | 1 | Host write strobe |
| wr_data | input | 9 | Character to send |
| wr_reject | output | 1 | Previous-cycle write was refused (busy) |
| rd_strobe | input | 1 | Host read of the receive buffer |
| rd_data | output | 9 | Receive buffer |
| ovf_clear | input | 1 | Write-one clear of the overflow flag |
| flag_dre | output | 1 | Holding register empty |
| flag_txc | output | 1 | Transmission complete, nothing pending |
| flag_rxc | output | 1 | Received character waiting |
| flag_ovf | output | 1 | Receive overflow (sticky) |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Suppose a write is sampled on edge t and the shifter is idle:
- flag_dre is low after t and high again after t+1, when the shifter loads.
- SCK edge k follows at edge t+1+k·(cfg_baud+1).
- flag_rxc, flag_txc and flag_ovf change on the edge that carries SCK edge 2·N.
- wr_reject shows one cycle after the refused write.

The bench drives and samples on the falling system clock, so every registered result has settled by then. A bench-side slave follows the SCK toggles it sees rather than absolute times. It checks the toggle spacing per frame. The host-side processes poll the flags and compare values one falling edge after each flag is seen.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int CHAR_W = 9;
  localparam int EDGE_W = $clog2(2 * CHAR_W + 1);

  typedef logic [CHAR_W-1:0] char_t;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb_first;
    logic nine_bit;
  } spi_cfg_t;
endpackage

// File: rtl/spi_eng_baud.sv
module spi_eng_baud #(
  parameter int BAUD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [BAUD_W-1:0] baud,
  output logic              tick
);
  logic [BAUD_W-1:0] cnt_q, cnt_n;

  assign tick = run & (cnt_q == baud);

  always_comb begin
    if (!run || tick) cnt_n = '0;
    else              cnt_n = cnt_q + BAUD_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter
  import spi_eng_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  spi_cfg_t cfg,
  input  logic     load,
  input  char_t    load_data,
  input  logic     tick,
  input  logic     miso,
  output logic     active,
  output logic     sck,
  output logic     mosi,
  output logic     frame_end,
  output char_t    rx_char
);
  localparam logic [EDGE_W-1:0] EDGES_SHORT = EDGE_W'(2 * (CHAR_W - 1));
  localparam logic [EDGE_W-1:0] EDGES_LONG  = EDGE_W'(2 * CHAR_W);

  logic              active_q, active_n;
  logic              phase_q, phase_n;
  logic [EDGE_W-1:0] ecnt_q, ecnt_n, edge_no;
  char_t             tx_q, tx_n, rx_q, rx_n, rx_shifted, rx_full;
  logic              lead, last_edge, do_sample, do_shift, step;

  assign step       = tick & active_q;
  assign edge_no    = ecnt_q + EDGE_W'(1);
  assign lead       = ~ecnt_q[0];
  assign last_edge  = edge_no == (cfg.nine_bit ? EDGES_LONG : EDGES_SHORT);
  assign do_sample  = step & (cfg.cpha ? ~lead : lead);
  assign do_shift   = step & (cfg.cpha ? (lead & (ecnt_q != '0)) : ~lead);
  assign frame_end  = step & last_edge;
  assign rx_shifted = cfg.lsb_first ? {miso, rx_q[CHAR_W-1:1]} : {rx_q[CHAR_W-2:0], miso};
  assign rx_full    = do_sample ? rx_shifted : rx_q;

  always_comb begin
    if (cfg.nine_bit)       rx_char = rx_full;
    else if (cfg.lsb_first) rx_char = {1'b0, rx_full[CHAR_W-1:1]};
    else                    rx_char = {1'b0, rx_full[CHAR_W-2:0]};
  end

  assign mosi   = cfg.lsb_first ? tx_q[0] : (cfg.nine_bit ? tx_q[CHAR_W-1] : tx_q[CHAR_W-2]);
  assign sck    = cfg.cpol ^ phase_q;
  assign active = active_q;

  always_comb begin
    active_n = active_q;
    phase_n  = phase_q;
    ecnt_n   = ecnt_q;
    tx_n     = tx_q;
    rx_n     = rx_q;
    if (load) begin
      active_n = 1'b1;
      phase_n  = 1'b0;
      ecnt_n   = '0;
      tx_n     = load_data;
    end else if (step) begin
      ecnt_n  = edge_no;
      phase_n = ~phase_q;
      if (do_sample) rx_n = rx_shifted;
      if (do_shift)  tx_n = cfg.lsb_first ? (tx_q >> 1) : (tx_q << 1);
      if (last_edge) active_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      ecnt_q   <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
    end else begin
      active_q <= active_n;
      phase_q  <= phase_n;
      ecnt_q   <= ecnt_n;
      tx_q     <= tx_n;
      rx_q     <= rx_n;
    end
  end
endmodule

// File: rtl/spi_eng_rxbuf.sv
module spi_eng_rxbuf
  import spi_eng_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push,
  input  char_t push_data,
  input  logic  rd,
  input  logic  ovf_clr,
  output char_t data,
  output logic  rxc,
  output logic  ovf
);
  char_t data_q;
  logic  rxc_q, rxc_n, ovf_q, ovf_n;

  always_comb begin
    rxc_n = rxc_q;
    if (push)    rxc_n = 1'b1;
    else if (rd) rxc_n = 1'b0;
    ovf_n = ovf_q;
    if (push && rxc_q) ovf_n = 1'b1;
    else if (ovf_clr)  ovf_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (push) data_q <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxc_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      rxc_q <= rxc_n;
      ovf_q <= ovf_n;
    end
  end

  assign data = data_q;
  assign rxc  = rxc_q;
  assign ovf  = ovf_q;
endmodule

// File: rtl/spi_master_engine.sv
module spi_master_engine
  import spi_eng_pkg::*;
#(
  parameter int BAUD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_lsb_first,
  input  logic              cfg_nine_bit,
  input  logic              cfg_rx_en,
  input  logic [BAUD_W-1:0] cfg_baud,
  input  logic              wr_valid,
  input  logic [8:0]        wr_data,
  output logic              wr_reject,
  input  logic              rd_strobe,
  output logic [8:0]        rd_data,
  input  logic              ovf_clear,
  output logic              flag_dre,
  output logic              flag_txc,
  output logic              flag_rxc,
  output logic              flag_ovf,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  spi_cfg_t cfg;
  char_t    hold_q, rx_char;
  logic     dre_q, dre_n, txc_q, txc_n, rej_q, rej_n;
  logic     shifting, tick, frame_end, load, accept;

  assign cfg = '{cpol: cfg_cpol, cpha: cfg_cpha, lsb_first: cfg_lsb_first, nine_bit: cfg_nine_bit};

  assign accept = wr_valid & dre_q;
  assign load   = ~shifting & ~dre_q;

  always_comb begin
    dre_n = dre_q;
    txc_n = txc_q;
    rej_n = wr_valid & ~dre_q;
    if (accept) begin
      dre_n = 1'b0;
      txc_n = 1'b0;
    end else if (load) begin
      dre_n = 1'b1;
    end
    if (frame_end && dre_q && !accept) txc_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= '0;
    else if (accept) hold_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dre_q <= 1'b1;
      txc_q <= 1'b0;
      rej_q <= 1'b0;
    end else begin
      dre_q <= dre_n;
      txc_q <= txc_n;
      rej_q <= rej_n;
    end
  end

  spi_eng_baud #(.BAUD_W(BAUD_W)) u_baud (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (shifting),
    .baud (cfg_baud),
    .tick (tick)
  );

  spi_eng_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg      (cfg),
    .load     (load),
    .load_data(hold_q),
    .tick     (tick),
    .miso     (miso),
    .active   (shifting),
    .sck      (sck),
    .mosi     (mosi),
    .frame_end(frame_end),
    .rx_char  (rx_char)
  );

  spi_eng_rxbuf u_rxbuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (frame_end & cfg_rx_en),
    .push_data(rx_char),
    .rd       (rd_strobe),
    .ovf_clr  (ovf_clear),
    .data     (rd_data),
    .rxc      (flag_rxc),
    .ovf      (flag_ovf)
  );

  assign flag_dre  = dre_q;
  assign flag_txc  = txc_q;
  assign wr_reject = rej_q;
endmodule

// File: rtl/spi_master_engine_chk.sv
module spi_master_engine_chk
  import spi_eng_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  wr_valid,
  input logic  flag_dre,
  input logic  flag_txc,
  input logic  flag_rxc,
  input logic  flag_ovf,
  input logic  cfg_rx_en,
  input logic  cfg_cpol,
  input logic  sck,
  input logic  shifting,
  input char_t hold_q
);
  p_reject_keeps_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !flag_dre) |=> $stable(hold_q));

  p_accept_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && flag_dre) |=> (!flag_dre && !flag_txc));

  p_sck_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !shifting |-> (sck == cfg_cpol));

  p_txc_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_txc |-> flag_dre);

  p_rx_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rx_en && !flag_rxc) |=> !flag_rxc);

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_ovf) |-> flag_rxc);
endmodule

bind spi_master_engine spi_master_engine_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .flag_dre (flag_dre),
  .flag_txc (flag_txc),
  .flag_rxc (flag_rxc),
  .flag_ovf (flag_ovf),
  .cfg_rx_en(cfg_rx_en),
  .cfg_cpol (cfg_cpol),
  .sck      (sck),
  .shifting (shifting),
  .hold_q   (hold_q)
);

// File: tb/spi_master_engine_tb.sv
module spi_master_engine_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0, cfg_nine_bit = 1'b0, cfg_rx_en = 1'b0;
  logic [7:0] cfg_baud = 8'd0;
  logic       wr_valid = 1'b0;
  logic [8:0] wr_data = 9'd0;
  logic       rd_strobe = 1'b0, ovf_clear = 1'b0, miso = 1'b0;
  logic       wr_reject, flag_dre, flag_txc, flag_rxc, flag_ovf, sck, mosi;
  logic [8:0] rd_data;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_master_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_lsb_first(cfg_lsb_first), .cfg_nine_bit(cfg_nine_bit), .cfg_rx_en(cfg_rx_en),
    .cfg_baud(cfg_baud), .wr_valid(wr_valid), .wr_data(wr_data), .wr_reject(wr_reject),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .ovf_clear(ovf_clear),
    .flag_dre(flag_dre), .flag_txc(flag_txc), .flag_rxc(flag_rxc), .flag_ovf(flag_ovf),
    .sck(sck), .mosi(mosi), .miso(miso)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] sword(input int f, input int nb);
    logic [8:0] v;
    v = 9'((f * 157 + 41) % 512);
    if (nb == 8) v[8] = 1'b0;
    return v;
  endfunction

  function automatic int nbits();
    return cfg_nine_bit ? 9 : 8;
  endfunction

  // Bench-side slave: follows SCK toggles, captures MOSI, drives MISO
  logic [8:0] exp_q[$];
  logic [8:0] capw, sw, ew;
  int ecount = 0, scount = 0, gap = 0, frame_no = 0, nb = 8, idx = 0;
  bit gap_ok = 1'b1;
  logic prev_sck = 1'b0, prev_cpol = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      ecount = 0; gap = 0; prev_sck = sck; prev_cpol = cfg_cpol; miso = 1'b0;
    end else begin
      nb = nbits();
      gap++;
      if (cfg_cpol != prev_cpol) begin
        prev_cpol = cfg_cpol;
        prev_sck  = sck;
      end else if (sck != prev_sck) begin
        prev_sck = sck;
        ecount++;
        if (ecount == 1) begin
          gap_ok = 1'b1; capw = '0; scount = 0;
        end else if (gap != int'(cfg_baud) + 1) begin
          gap_ok = 1'b0;
        end
        gap = 0;
        if (cfg_cpha ? (ecount % 2 == 0) : (ecount % 2 == 1)) begin
          if (cfg_lsb_first) capw[scount] = mosi;
          else               capw[nb-1-scount] = mosi;
          scount++;
        end
        if (ecount == 2 * nb) begin
          chk(gap_ok, "R4 sck half period", 0, 1);
          if (exp_q.size() == 0) begin
            chk(1'b0, "R2 unexpected frame on mosi", int'(capw), 0);
          end else begin
            ew = exp_q.pop_front();
            chk(capw == ew, "R5 R6 R7 mosi character", int'(capw), int'(ew));
          end
          frame_no++;
          ecount = 0;
        end
      end
      idx = (ecount == 0) ? 0 : (cfg_cpha ? (ecount - 1) / 2 : ecount / 2);
      if (idx > nb - 1) idx = nb - 1;
      sw = sword(frame_no, nb);
      miso = cfg_lsb_first ? sw[idx] : sw[nb-1-idx];
    end
  end

  task automatic set_cfg(input bit pol, input bit pha, input bit lsb, input bit nine,
                         input int baud, input bit rxe);
    @(negedge clk);
    cfg_cpol = pol; cfg_cpha = pha; cfg_lsb_first = lsb; cfg_nine_bit = nine;
    cfg_baud = 8'(baud); cfg_rx_en = rxe;
    @(negedge clk);
  endtask

  task automatic send(input logic [8:0] w);
    while (!flag_dre) @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = w;
    exp_q.push_back(cfg_nine_bit ? w : {1'b0, w[7:0]});
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_txc();
    while (!flag_txc) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic reader(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      logic [8:0] e;
      while (!flag_rxc) @(negedge clk);
      e = sword(base + i, nbits());
      chk(rd_data == e, "R9 received character", int'(rd_data), int'(e));
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
    end
  endtask

  task automatic run_batch(input int n);
    int base;
    base = frame_no;
    fork
      begin
        for (int i = 0; i < n; i++) send(9'($urandom));
        wait_txc();
      end
      reader(n, base);
    join
    chk(flag_txc == 1'b1, "R8 txc after last frame", int'(flag_txc), 1);
    chk(sck == cfg_cpol, "R4 sck idle level", int'(sck), int'(cfg_cpol));
    chk(exp_q.size() == 0, "R3 all characters sent", exp_q.size(), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [8:0] keep;
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(flag_dre == 1'b1, "R1 dre", int'(flag_dre), 1);
    chk(flag_txc == 1'b0, "R1 txc", int'(flag_txc), 0);
    chk(flag_rxc == 1'b0, "R1 rxc", int'(flag_rxc), 0);
    chk(flag_ovf == 1'b0, "R1 ovf", int'(flag_ovf), 0);
    chk(wr_reject == 1'b0, "R1 wr_reject", int'(wr_reject), 0);
    chk(rd_data == 9'd0, "R1 rd_data", int'(rd_data), 0);
    chk(sck == 1'b0, "R1 sck", int'(sck), 0);

    // R2/R3 directed: refused write, receiver off (R9)
    set_cfg(1'b0, 1'b0, 1'b0, 1'b1, 3, 1'b0);
    keep = rd_data;
    wr_valid = 1'b1; wr_data = 9'h1A5; exp_q.push_back(9'h1A5);
    @(negedge clk);
    wr_valid = 1'b0;
    chk(flag_dre == 1'b0, "R3 dre low after write", int'(flag_dre), 0);
    chk(flag_txc == 1'b0, "R8 txc low after write", int'(flag_txc), 0);
    @(negedge clk);
    chk(flag_dre == 1'b1, "R3 dre high after load", int'(flag_dre), 1);
    wr_valid = 1'b1; wr_data = 9'h05A; exp_q.push_back(9'h05A);
    @(negedge clk);
    wr_data = 9'h0FF;
    @(negedge clk);
    wr_valid = 1'b0;
    chk(wr_reject == 1'b1, "R2 wr_reject pulse", int'(wr_reject), 1);
    chk(flag_dre == 1'b0, "R2 holding still full", int'(flag_dre), 0);
    @(negedge clk);
    chk(wr_reject == 1'b0, "R2 wr_reject one cycle", int'(wr_reject), 0);
    wait_txc();
    chk(exp_q.size() == 0, "R2 only accepted characters sent", exp_q.size(), 0);
    chk(flag_rxc == 1'b0, "R9 rxc stays low with receiver off", int'(flag_rxc), 0);
    chk(rd_data == keep, "R9 buffer unchanged with receiver off", int'(rd_data), int'(keep));

    // R10 overflow, mode 3, LSB first, 8-bit
    set_cfg(1'b1, 1'b1, 1'b1, 1'b0, 1, 1'b1);
    begin
      int base;
      logic [8:0] e;
      base = frame_no;
      send(9'h1C3);
      send(9'h03C);
      wait_txc();
      e = sword(base + 1, 8);
      chk(flag_rxc == 1'b1, "R9 rxc set", int'(flag_rxc), 1);
      chk(flag_ovf == 1'b1, "R10 overflow set", int'(flag_ovf), 1);
      chk(rd_data == e, "R10 newest character kept", int'(rd_data), int'(e));
      chk(rd_data[8] == 1'b0, "R7 ninth bit zero", int'(rd_data[8]), 0);
      ovf_clear = 1'b1;
      @(negedge clk);
      ovf_clear = 1'b0;
      chk(flag_ovf == 1'b0, "R10 overflow cleared", int'(flag_ovf), 0);
      chk(flag_rxc == 1'b1, "R10 rxc kept by clear", int'(flag_rxc), 1);
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
      chk(flag_rxc == 1'b0, "R9 rxc cleared by read", int'(flag_rxc), 0);
    end

    // Directed corners then random mix of modes, order, size, divider
    set_cfg(1'b0, 1'b1, 1'b0, 1'b1, 0, 1'b1);
    run_batch(3);
    set_cfg(1'b1, 1'b0, 1'b1, 1'b1, 0, 1'b1);
    run_batch(3);
    for (int b = 0; b < 12; b++) begin
      set_cfg(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 4), 1'b1);
      run_batch(2 + int'($urandom % 4));
    end
    chk(flag_ovf == 1'b0, "R10 no overflow when read promptly", int'(flag_ovf), 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule